// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

A byte-wide, register-mapped timer with three independent 16-bit channels. Each channel is programmed through a shared control port. Counts are written and read through the channel's own data port. All channels advance on a common count-enable strobe (`tick`), so the timebase is set by whatever logic pulses that strobe. Each channel runs one of six waveform modes. The output level and the value read back are both functions of the number of ticks since the count was loaded or last restarted by its gate.

Channels 0 and 1 take their gate from pins. Channel 2 takes its gate from a small system-control port. That port also holds an enable flag, reports the channel 2 output and returns a refresh bit that flips on every read. All three outputs are exported as plain levels.

The bus address selects the port: addresses 0, 1 and 2 are the channel data ports and address 3 is the control port.

Top module: `pit_timer`

## Requirements
- R1: After reset every channel is unprogrammed and drives output 0. Its count is the 0 value, so a word read returns 0x00 then 0x00. Its access sequencing is word (low byte, then high byte). The channel 2 gate and the enable flag are 0.
- R2: Control word fields:
  - bits 7:6 pick the channel (0..2);
  - bits 5:4 pick the access: 1 = low byte only, 2 = high byte only, 3 = low then high;
  - bits 3:1 pick the mode, with 6 and 7 acting as 2 and 3;
  - bit 0 is stored as the BCD flag.
  A count is loaded when its last byte is written, and reads follow the same byte sequence.
- R3: A loaded count of 0 counts as 65536 ticks.
- R4: Mode 0 output rises when the elapsed ticks reach the count. Mode 1 output is high while the elapsed ticks are below the count. Both hold their final level until a new count is loaded. In these modes, and in modes 4 and 5, readback is (count − elapsed) modulo 65536.
- R5: Mode 2 output is high for one tick whenever the elapsed ticks are a nonzero multiple of the count. Readback is count − (elapsed mod count).
- R6: Mode 3 output is high during the first (count+1)/2 ticks of each period. Readback is count − ((2·elapsed) mod count).
- R7: Modes 4 and 5 output is high only while the elapsed ticks equal the count.
- R8: A rising gate restarts the elapsed count from zero in modes 1, 2, 3 and 5. It has no effect in modes 0 and 4.
- R9: Access value 0 latches the channel's current readback value. Further latch commands are ignored until the latched bytes have been read out.
- R10: A control word with bits 7:6 = 3 is a read-back command:
  - bits 1, 2 and 3 select channels 0, 1 and 2;
  - bit 4 = 0 latches status, bit 5 = 0 latches the count.
  The status byte is {output, 0, access[1:0], mode[2:0], BCD}. A pending status is read before any count byte and is not overwritten while pending.
- R11: A read at address 3 returns 0 and changes no read sequencing.
- R12: A system-port write sets the channel 2 gate from bit 0 and the enable flag from bit 1. A system-port read returns the gate in bit 0, the flag in bit 1, a refresh bit in bit 4 (1 on the first read after reset, inverting on each read) and the channel 2 output in bit 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Shared count-enable strobe |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 2 | Port select: 0..2 data, 3 control |
| wdata | input | 8 | Bus write byte |
| rdata | output | 8 | Bus read byte, valid while rd_en is high |
| gate_in | input | 2 | Gates of channels 0 and 1 |
| sys_wr | input | 1 | System-port write strobe |
| sys_rd | input | 1 | System-port read strobe |
| sys_wdata | input | 2 | System-port write bits: flag (1), channel 2 gate (0) |
| sys_rdata | output | 8 | System-port read byte |
| spk_en | output | 1 | Enable flag held by the system port |
| timer_out | output | 3 | Channel output levels |

## Verification
The bench goes after the cases where the counting arithmetic wraps or folds:
- Mode 0 read after expiry must wrap to 0xFFFD. A saturating down-counter would return zero.
- A zero load read after one tick must give 0xFFFF. A design that took zero as zero would read 0xFFFF only by luck and would expire at once.
- Mode 2 and mode 3 reads at period boundaries must return the full count and the folded double-rate value. An off-by-one in the fold shows up as 4 instead of 5.

Latch precedence is also checked:
- A second latch or status command while one is pending must be ignored.
- Status must come out before the latched count.
- A control-port read must not advance the word sequence; a design that did would return the high byte first.

Gate edges are driven in restart and non-restart modes. A design that restarts in mode 0 would drop the expired output.

// File: rtl/pit_pkg.sv
package pit_pkg;

   typedef enum logic [2:0] {
      SEQ_LSB = 3'd1,
      SEQ_MSB = 3'd2,
      SEQ_LO  = 3'd3,
      SEQ_HI  = 3'd4
   } seq_e;

   function automatic seq_e seq_from_access(input logic [1:0] acc);
      case (acc)
         2'd1:    return SEQ_LSB;
         2'd2:    return SEQ_MSB;
         default: return SEQ_LO;
      endcase
   endfunction

   // modes 6 and 7 behave as 2 and 3
   function automatic logic [2:0] eff_mode(input logic [2:0] m);
      return m[1] ? {1'b0, m[1:0]} : m;
   endfunction

endpackage

// File: rtl/pit_counter.sv
module pit_counter
   import pit_pkg::*;
#(
   parameter int   CW       = 16,
   parameter logic GATE_RST = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       gate,
   input  logic       ctl_we,
   input  logic [5:0] ctl_byte,
   input  logic       latch_cnt,
   input  logic       latch_sts,
   input  logic       data_we,
   input  logic       data_re,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       out_o
);
   localparam int FW = CW + 1;
   localparam logic [FW-1:0] FULL = FW'(1) << CW;

   if (CW != 16) begin : g_cw_check
      $error("pit_counter: byte access needs CW == 16");
   end

   logic [FW-1:0] cnt, left, phase, half, fold;
   logic [FW:0]   dbl;
   logic [CW-1:0] rd, lat, cur, ld_val;
   logic [FW-1:0] ld_full;
   logic          started, over, armed, bcd, gate_q, cl_v, sl_v;
   logic [2:0]    mode, em;
   logic [1:0]    acc;
   logic [7:0]    wlo, sts;
   seq_e          wseq, rseq, lseq;
   logic          load_now, restart;

   always_comb begin
      em   = eff_mode(mode);
      half = (cnt + FW'(1)) >> 1;
      dbl  = {phase, 1'b0};
      fold = (dbl >= {1'b0, cnt}) ? FW'(dbl - {1'b0, cnt}) : FW'(dbl);
      case (em)
         3'd2:    cur = CW'(cnt - phase);
         3'd3:    cur = CW'(cnt - fold);
         default: cur = rd;
      endcase
      if (!armed) out_o = 1'b0;
      else begin
         case (em)
            3'd0:    out_o = (left == '0);
            3'd1:    out_o = (left != '0);
            3'd2:    out_o = (phase == '0) && started;
            3'd3:    out_o = (phase < half);
            default: out_o = (left == '0) && !over;
         endcase
      end
      load_now = data_we && (wseq != SEQ_LO);
      case (wseq)
         SEQ_LSB: ld_val = {8'h00, wdata};
         SEQ_MSB: ld_val = {wdata, 8'h00};
         default: ld_val = {wdata, wlo};
      endcase
      ld_full = (ld_val == '0) ? FULL : {1'b0, ld_val};
      restart = gate && !gate_q &&
                (em == 3'd1 || em == 3'd2 || em == 3'd3 || em == 3'd5);
      if (sl_v)      rdata = sts;
      else if (cl_v) rdata = (lseq == SEQ_MSB || lseq == SEQ_HI) ? lat[15:8] : lat[7:0];
      else           rdata = (rseq == SEQ_MSB || rseq == SEQ_HI) ? cur[15:8] : cur[7:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= FULL; left <= FULL; phase <= '0; rd <= '0;
         started <= 1'b0; over <= 1'b0; armed <= 1'b0;
         mode <= 3'd0; acc <= 2'd3; bcd <= 1'b0; wlo <= 8'h00;
         wseq <= SEQ_LO; rseq <= SEQ_LO; lseq <= SEQ_LO;
         cl_v <= 1'b0; sl_v <= 1'b0; lat <= '0; sts <= 8'h00;
         gate_q <= GATE_RST;
      end else begin
         gate_q <= gate;
         if (load_now) begin
            cnt <= ld_full; left <= ld_full; rd <= ld_val;
            phase <= '0; started <= 1'b0; over <= 1'b0;
         end else if (restart) begin
            left <= cnt; rd <= cnt[CW-1:0];
            phase <= '0; started <= 1'b0; over <= 1'b0;
         end else if (tick) begin
            rd      <= rd - CW'(1);
            phase   <= (phase + FW'(1) == cnt) ? '0 : phase + FW'(1);
            started <= 1'b1;
            if (left != '0) left <= left - FW'(1);
            else            over <= 1'b1;
         end
         if (data_we) begin
            if (wseq == SEQ_LO) begin
               wlo  <= wdata;
               wseq <= SEQ_HI;
            end else if (wseq == SEQ_HI) wseq <= SEQ_LO;
         end
         if (ctl_we) begin
            acc   <= ctl_byte[5:4];
            mode  <= ctl_byte[3:1];
            bcd   <= ctl_byte[0];
            wseq  <= seq_from_access(ctl_byte[5:4]);
            rseq  <= seq_from_access(ctl_byte[5:4]);
            armed <= 1'b1;
         end
         if (latch_cnt && !cl_v) begin
            lat  <= cur;
            cl_v <= 1'b1;
            lseq <= seq_from_access(acc);
         end
         if (latch_sts && !sl_v) begin
            sts  <= {out_o, 1'b0, acc, mode, bcd};
            sl_v <= 1'b1;
         end
         if (data_re) begin
            if (sl_v) sl_v <= 1'b0;
            else if (cl_v) begin
               if (lseq == SEQ_LO) lseq <= SEQ_MSB;
               else                cl_v <= 1'b0;
            end else if (rseq == SEQ_LO) rseq <= SEQ_HI;
            else if (rseq == SEQ_HI)     rseq <= SEQ_LO;
         end
      end
   end

   // R4: mode 0 holds its terminal level until a reload
   assert_m0_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && mode == 3'd0 && out_o && !load_now && !ctl_we) |=> out_o);

   // R5: mode 2 pulse lasts one tick
   assert_m2_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && em == 3'd2 && out_o && tick && cnt != FW'(1) && !load_now && !restart && !ctl_we)
      |=> !out_o);

   // R7: modes 4 and 5 strobe for one tick
   assert_m45_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && (em == 3'd4 || em == 3'd5) && out_o && tick && !load_now && !restart && !ctl_we)
      |=> !out_o);

   // R9: a pending count latch is not overwritten
   assert_cnt_latch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cl_v && !data_re) |=> (cl_v && $stable(lat)));

   // R10: a pending status latch is not overwritten
   assert_sts_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sl_v && !data_re) |=> (sl_v && $stable(sts)));

endmodule

// File: rtl/pit_sysctl.sv
module pit_sysctl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic       rd,
   input  logic [1:0] wbits,
   input  logic       ch2_out,
   output logic [7:0] rdata,
   output logic       gate2,
   output logic       spk
);
   logic refresh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate2   <= 1'b0;
         spk     <= 1'b0;
         refresh <= 1'b0;
      end else begin
         if (wr) begin
            gate2 <= wbits[0];
            spk   <= wbits[1];
         end
         if (rd) refresh <= ~refresh;
      end
   end

   assign rdata = {2'b00, ch2_out, ~refresh, 2'b00, spk, gate2};

   // R12: the refresh bit seen by consecutive reads alternates
   assert_refresh_alt_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !wr) |=> (rdata[4] != $past(rdata[4])));

endmodule

// File: rtl/pit_timer.sv
module pit_timer
   import pit_pkg::*;
#(
   parameter int NCH = 3,
   parameter int CW  = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  logic           wr_en,
   input  logic           rd_en,
   input  logic [1:0]     addr,
   input  logic [7:0]     wdata,
   output logic [7:0]     rdata,
   input  logic [1:0]     gate_in,
   input  logic           sys_wr,
   input  logic           sys_rd,
   input  logic [1:0]     sys_wdata,
   output logic [7:0]     sys_rdata,
   output logic           spk_en,
   output logic [NCH-1:0] timer_out
);
   localparam logic [1:0] CTL_ADDR = 2'd3;

   if (NCH != 3) begin : g_nch_check
      $error("pit_timer: address map holds exactly three channels");
   end

   logic [7:0] ch_rd [NCH];
   logic       gate2;
   logic       ctl_hit;
   logic [1:0] sel;

   assign ctl_hit = wr_en && (addr == CTL_ADDR);
   assign sel     = wdata[7:6];

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic g, cwe, lc, ls, dwe, dre;
      if (i < 2) begin : g_pin
         assign g = gate_in[i];
      end else begin : g_sys
         assign g = gate2;
      end
      assign cwe = ctl_hit && (sel == 2'(i)) && (wdata[5:4] != 2'd0);
      assign lc  = ctl_hit && (((sel == 2'(i)) && (wdata[5:4] == 2'd0)) ||
                              ((sel == CTL_ADDR) && wdata[i+1] && !wdata[5]));
      assign ls  = ctl_hit && (sel == CTL_ADDR) && wdata[i+1] && !wdata[4];
      assign dwe = wr_en && (addr == 2'(i));
      assign dre = rd_en && (addr == 2'(i));

      pit_counter #(.CW(CW), .GATE_RST(i != 2)) u_cnt (
         .clk(clk), .rst_n(rst_n), .tick(tick), .gate(g),
         .ctl_we(cwe), .ctl_byte(wdata[5:0]),
         .latch_cnt(lc), .latch_sts(ls),
         .data_we(dwe), .data_re(dre), .wdata(wdata),
         .rdata(ch_rd[i]), .out_o(timer_out[i])
      );
   end

   pit_sysctl u_sys (
      .clk(clk), .rst_n(rst_n), .wr(sys_wr), .rd(sys_rd), .wbits(sys_wdata),
      .ch2_out(timer_out[2]), .rdata(sys_rdata), .gate2(gate2), .spk(spk_en)
   );

   always_comb begin
      if (addr == CTL_ADDR) rdata = 8'h00;
      else                  rdata = ch_rd[addr];
   end

endmodule

// File: tb/sim_pit_timer.sv
`timescale 1ns/1ps
module sim_pit_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic [1:0] gate_in = 2'b11;
   logic       sys_wr = 1'b0, sys_rd = 1'b0;
   logic [1:0] sys_wdata = 2'b00;
   logic [7:0] sys_rdata;
   logic       spk_en;
   logic [2:0] timer_out;

   int vecs = 0;
   int errs = 0;
   bit done = 1'b0;

   typedef struct { logic [7:0] exp; string tag; bit sys; } item_t;
   item_t sbq[$];

   always #4 clk = ~clk;

   pit_timer u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .gate_in(gate_in),
      .sys_wr(sys_wr), .sys_rd(sys_rd), .sys_wdata(sys_wdata),
      .sys_rdata(sys_rdata), .spk_en(spk_en), .timer_out(timer_out)
   );

   // monitor: pops one expected byte per read cycle
   always @(negedge clk) begin
      if (rd_en || sys_rd) begin
         vecs++;
         if (sbq.size() == 0) begin
            errs++;
            $display("FAIL unexpected read: actual %02h expected none", rd_en ? rdata : sys_rdata);
         end else begin
            item_t it;
            logic [7:0] act;
            it  = sbq.pop_front();
            act = it.sys ? sys_rdata : rdata;
            if (act !== it.exp) begin
               errs++;
               $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      @(posedge clk); #1; addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk); #1; wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, input logic [7:0] e, input string t);
      @(posedge clk); #1; sbq.push_back('{e, t, 1'b0}); addr = a; rd_en = 1'b1;
      @(posedge clk); #1; rd_en = 1'b0;
   endtask

   task automatic sys_w(input logic [1:0] d);
      @(posedge clk); #1; sys_wdata = d; sys_wr = 1'b1;
      @(posedge clk); #1; sys_wr = 1'b0;
   endtask

   task automatic sys_r(input logic [7:0] e, input string t);
      @(posedge clk); #1; sbq.push_back('{e, t, 1'b1}); sys_rd = 1'b1;
      @(posedge clk); #1; sys_rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      @(posedge clk); #1; tick = 1'b1;
      repeat (n) @(posedge clk);
      #1; tick = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic gate_pulse(input int ch);
      @(posedge clk); #1; gate_in[ch] = 1'b0;
      @(posedge clk); #1; gate_in[ch] = 1'b1;
      @(posedge clk); #1;
   endtask

   task automatic chk_out(input int ch, input logic e, input string t);
      @(negedge clk);
      vecs++;
      if (timer_out[ch] !== e) begin
         errs++;
         $display("FAIL %s: out%0d actual %0b expected %0b", t, ch, timer_out[ch], e);
      end
   endtask

   initial begin
      #(8 * 150000);
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk_out(0, 1'b0, "R1 out0");
      chk_out(1, 1'b0, "R1 out1");
      chk_out(2, 1'b0, "R1 out2");
      bus_rd(2'd0, 8'h00, "R1 ch0 lo");
      bus_rd(2'd0, 8'h00, "R1 ch0 hi");
      sys_r(8'h10, "R1 sys read");

      // R2 word access, R4 mode 0
      bus_wr(2'd3, 8'h30);
      bus_wr(2'd0, 8'h05);
      bus_wr(2'd0, 8'h00);
      chk_out(0, 1'b0, "R4 m0 after load");
      ticks(4);
      chk_out(0, 1'b0, "R4 m0 before expiry");
      bus_rd(2'd0, 8'h01, "R2 word lo");
      bus_rd(2'd0, 8'h00, "R2 word hi");
      ticks(1);
      chk_out(0, 1'b1, "R4 m0 expiry");
      ticks(3);
      chk_out(0, 1'b1, "R4 m0 held");
      bus_rd(2'd0, 8'hFD, "R4 wrap lo");
      bus_rd(2'd0, 8'hFF, "R4 wrap hi");
      bus_wr(2'd0, 8'h03);
      bus_wr(2'd0, 8'h00);
      chk_out(0, 1'b0, "R4 m0 reload clears");

      // R2 single-byte access
      bus_wr(2'd3, 8'h50);
      bus_wr(2'd1, 8'h07);
      bus_rd(2'd1, 8'h07, "R2 lsb-only 1");
      bus_rd(2'd1, 8'h07, "R2 lsb-only 2");
      bus_wr(2'd3, 8'h60);
      bus_wr(2'd1, 8'h02);
      bus_rd(2'd1, 8'h02, "R2 msb-only 1");
      bus_rd(2'd1, 8'h02, "R2 msb-only 2");

      // R3 zero count
      bus_wr(2'd3, 8'h70);
      bus_wr(2'd1, 8'h00);
      bus_wr(2'd1, 8'h00);
      ticks(1);
      chk_out(1, 1'b0, "R3 zero not expired");
      bus_rd(2'd1, 8'hFF, "R3 zero lo");
      bus_rd(2'd1, 8'hFF, "R3 zero hi");

      // R4 mode 1, R8 gate restart
      bus_wr(2'd3, 8'h72);
      bus_wr(2'd1, 8'h04);
      bus_wr(2'd1, 8'h00);
      chk_out(1, 1'b1, "R4 m1 high");
      ticks(4);
      chk_out(1, 1'b0, "R4 m1 expiry");
      ticks(2);
      chk_out(1, 1'b0, "R4 m1 held");
      gate_pulse(1);
      chk_out(1, 1'b1, "R8 m1 restart");
      ticks(3);
      chk_out(1, 1'b1, "R8 m1 counting");
      ticks(1);
      chk_out(1, 1'b0, "R8 m1 expiry after restart");
      chk_out(0, 1'b1, "R8 m0 before gate");
      gate_pulse(0);
      chk_out(0, 1'b1, "R8 m0 gate ignored");

      // R5 mode 2
      bus_wr(2'd3, 8'h34);
      bus_wr(2'd0, 8'h04);
      bus_wr(2'd0, 8'h00);
      chk_out(0, 1'b0, "R5 m2 load");
      ticks(3);
      chk_out(0, 1'b0, "R5 m2 mid");
      bus_rd(2'd0, 8'h01, "R5 read lo");
      bus_rd(2'd0, 8'h00, "R5 read hi");
      ticks(1);
      chk_out(0, 1'b1, "R5 m2 pulse");
      bus_rd(2'd0, 8'h04, "R5 read at wrap");
      bus_rd(2'd0, 8'h00, "R5 read at wrap hi");
      ticks(1);
      chk_out(0, 1'b0, "R5 m2 pulse end");
      bus_rd(2'd0, 8'h03, "R5 read after wrap");
      bus_rd(2'd0, 8'h00, "R5 read after wrap hi");
      ticks(3);
      chk_out(0, 1'b1, "R5 m2 second pulse");

      // R6 mode 3 on channel 2, R12 system port
      bus_wr(2'd3, 8'hB6);
      bus_wr(2'd2, 8'h05);
      bus_wr(2'd2, 8'h00);
      chk_out(2, 1'b1, "R6 m3 high");
      sys_r(8'h20, "R12 out2 in bit5");
      ticks(3);
      chk_out(2, 1'b0, "R6 m3 low half");
      bus_rd(2'd2, 8'h04, "R6 fold read");
      bus_rd(2'd2, 8'h00, "R6 fold read hi");
      ticks(2);
      chk_out(2, 1'b1, "R6 m3 new period");
      bus_rd(2'd2, 8'h05, "R6 period read");
      bus_rd(2'd2, 8'h00, "R6 period read hi");
      ticks(1);
      bus_rd(2'd2, 8'h03, "R6 double read");
      bus_rd(2'd2, 8'h00, "R6 double read hi");
      sys_w(2'b11);
      idle(1);
      bus_rd(2'd2, 8'h05, "R8 sys gate restart");
      bus_rd(2'd2, 8'h00, "R8 sys gate restart hi");
      chk_out(2, spk_en, "R12 enable flag");
      sys_r(8'h33, "R12 gate flag refresh");
      sys_r(8'h23, "R12 refresh toggles");

      // R7 modes 4 and 5
      bus_wr(2'd3, 8'h78);
      bus_wr(2'd1, 8'h02);
      bus_wr(2'd1, 8'h00);
      ticks(1);
      chk_out(1, 1'b0, "R7 m4 before");
      ticks(1);
      chk_out(1, 1'b1, "R7 m4 strobe");
      ticks(1);
      chk_out(1, 1'b0, "R7 m4 after");
      bus_wr(2'd3, 8'h7A);
      bus_wr(2'd1, 8'h02);
      bus_wr(2'd1, 8'h00);
      ticks(3);
      chk_out(1, 1'b0, "R7 m5 past");
      gate_pulse(1);
      ticks(2);
      chk_out(1, 1'b1, "R8 m5 restart strobe");

      // R9 count latch
      bus_wr(2'd3, 8'h30);
      bus_wr(2'd0, 8'h10);
      bus_wr(2'd0, 8'h00);
      ticks(2);
      bus_wr(2'd3, 8'h00);
      ticks(3);
      bus_wr(2'd3, 8'h00);
      bus_rd(2'd0, 8'h0E, "R9 latched lo");
      bus_rd(2'd0, 8'h00, "R9 latched hi");
      bus_rd(2'd0, 8'h0B, "R9 live lo");
      bus_rd(2'd0, 8'h00, "R9 live hi");

      // R10 status latch
      bus_wr(2'd3, 8'hE2);
      ticks(20);
      bus_wr(2'd3, 8'hE2);
      bus_rd(2'd0, 8'h30, "R10 first status kept");
      bus_rd(2'd0, 8'hF7, "R10 count after status lo");
      bus_rd(2'd0, 8'hFF, "R10 count after status hi");
      bus_wr(2'd3, 8'hE2);
      bus_rd(2'd0, 8'hB0, "R10 status with out high");

      // R11 control port read
      bus_rd(2'd3, 8'h00, "R11 control read");
      bus_rd(2'd0, 8'hF7, "R11 sequence untouched lo");
      bus_rd(2'd0, 8'hFF, "R11 sequence untouched hi");

      idle(2);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule